// File: doc/BRIEF.md
# Transmit Holding Controller for a Parallel USB 2.0 Transceiver Interface

This block sits on the transceiver side of a byte-wide or word-wide parallel link between a USB 2.0 protocol engine and its line interface. The engine raises a transmit-valid line and presents data. The controller first asks the line stage for a SYNC pattern after a delay that depends on the speed mode. It then raises transmit-ready. Every word handed over with valid and ready both high is latched into a holding register. When transmit-valid falls, the controller asks for an end-of-packet sequence.

The operating mode input can silence the transmitter (non-driving and reserved codes) or flag that the line stage must bypass bit stuffing and NRZI coding. The 8/16-bit data path choice is captured only while reset is asserted. In 16-bit mode a high-byte qualifier from the engine marks whether the upper byte of each word is to be sent. Downstream stages read an abstract stream: the holding register, its low-byte and high-byte valid strobes, and the SYNC and EOP requests.

Top module: `txh_ctrl`

## Requirements
- R1: While reset is low and in the cycle after it is released, tx_ready, sync_req, eop_req, hold_lo_vld and hold_hi_vld are all low.
- R2: In full-speed mode (fs_sel=1), sync_req goes high FS_SYNC_CLKS rising edges after the first edge at which the idle controller samples tx_valid high, and stays high for exactly one cycle.
- R3: In high-speed mode (fs_sel=0), the SYNC delay in clocks is HS_SYNC_BITS divided by the bit times per clock, rounded up and at least 1. There are NARROW_BITS bit times per clock on the 8-bit path and twice that on the 16-bit path, so the defaults give 2 clocks narrow and 1 clock wide.
- R4: tx_ready first goes high in the cycle right after the sync_req cycle, and is never high together with sync_req or eop_req.
- R5: At a rising edge where tx_valid and tx_ready are both high, the word is latched, and hold_lo_vld is high in the following cycle. After an edge without that handshake, hold_lo_vld is low.
- R6: hold_hi_vld equals the latched 16-bit mode ANDed with tx_hi_ok at the handshake edge. hold_data[15:8] carries the input high byte when hold_hi_vld is set and is zero otherwise, so the 8-bit path always yields a zero upper byte.
- R7: When tx_valid is low at a rising edge while tx_ready is high, eop_req is high for exactly EOP_CLKS cycles starting after that edge, tx_ready drops at that edge, and the controller is then idle.
- R8: Mode codes 01 (non-driving) and 11 (reserved) hold tx_ready, sync_req and eop_req low combinationally. Under these modes no word is latched (hold_lo_vld low after any edge at which mode_i[0]=1), and a packet in progress is abandoned without EOP.
- R9: The 8/16-bit selection is taken from wide_sel only while rst_n is low. Changing wide_sel after reset changes neither the SYNC delay nor the byte qualification.
- R10: raw_line is high exactly when mode_i is 10. In that mode the packet proceeds as in normal mode 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Synchronous active-low reset; wide_sel is sampled while low |
| mode_i | input | 2 | Operating mode: 00 normal, 01 non-driving, 10 raw line, 11 reserved |
| fs_sel | input | 1 | Speed select: 1 full speed, 0 high speed |
| wide_sel | input | 1 | Data path select captured during reset: 1 for 16-bit, 0 for 8-bit |
| tx_valid | input | 1 | Engine has a packet in progress and valid data |
| tx_data | input | DATA_W | Transmit word from the engine |
| tx_hi_ok | input | 1 | Upper byte of tx_data is valid (16-bit path only) |
| tx_ready | output | 1 | Controller accepts tx_data at this edge |
| sync_req | output | 1 | One-cycle request to start a SYNC pattern |
| eop_req | output | 1 | End-of-packet request, EOP_CLKS cycles long |
| raw_line | output | 1 | Line stage must skip bit stuffing and NRZI |
| hold_data | output | DATA_W | Transmit holding register |
| hold_lo_vld | output | 1 | Low byte of hold_data is newly loaded |
| hold_hi_vld | output | 1 | High byte of hold_data is newly loaded |

## Verification
The bench builds the block with its defaults: DATA_W=16, FS_SYNC_CLKS=1, HS_SYNC_BITS=16, NARROW_BITS=8 and EOP_CLKS=2. With these values the high-speed narrow delay (2 clocks) differs from both the wide and the full-speed delay (1 clock), so a wrong speed or width choice shows up as a miscounted edge. A two-cycle EOP separates a correct burst from a single-cycle strobe. Each vector resets the block with one path width and then drives the opposite value on wide_sel, so every packet also probes that the width is held static.

// File: rtl/txh_pkg.sv
package txh_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SYNC_WAIT,
    ST_SEND_SYNC,
    ST_DATA,
    ST_SEND_EOP
  } txh_state_e;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_QUIET  = 2'b01,
    MODE_RAW    = 2'b10,
    MODE_RSVD   = 2'b11
  } txh_mode_e;

  // A mode drives the line unless it is non-driving or reserved.
  function automatic logic mode_drives(input logic [1:0] m);
    return (m == MODE_NORMAL) || (m == MODE_RAW);
  endfunction

  // SYNC launch delay in clocks, counted from the edge that detects tx_valid.
  function automatic int unsigned sync_delay_clks(
    input logic        fs,
    input logic        wide,
    input int unsigned fs_clks,
    input int unsigned hs_bits,
    input int unsigned narrow_bits
  );
    int unsigned bpc;
    int unsigned d;
    if (fs) begin
      d = fs_clks;
    end else begin
      bpc = wide ? narrow_bits * 2 : narrow_bits;
      d   = (hs_bits + bpc - 1) / bpc;
    end
    if (d == 0) d = 1;
    return d;
  endfunction

endpackage

// File: rtl/txh_seq.sv
module txh_seq
  import txh_pkg::*;
#(
  parameter int unsigned FS_SYNC_CLKS = 1,
  parameter int unsigned HS_SYNC_BITS = 16,
  parameter int unsigned NARROW_BITS  = 8,
  parameter int unsigned EOP_CLKS     = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       drive,
  input  logic       fs,
  input  logic       wide,
  input  logic       tx_valid,
  output txh_state_e state,
  output logic       sync_req,
  output logic       eop_req,
  output logic       ready
);

  localparam int unsigned HS_NARROW = (HS_SYNC_BITS + NARROW_BITS - 1) / NARROW_BITS;
  localparam int unsigned MAX_A     = (HS_NARROW > FS_SYNC_CLKS) ? HS_NARROW : FS_SYNC_CLKS;
  localparam int unsigned MAX_CNT   = (MAX_A > EOP_CLKS) ? MAX_A : EOP_CLKS;
  localparam int unsigned CNT_W     = (MAX_CNT < 2) ? 1 : $clog2(MAX_CNT + 1);

  txh_state_e       st_q, st_nxt;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic [CNT_W-1:0] dly;

  assign dly = CNT_W'(sync_delay_clks(fs, wide, FS_SYNC_CLKS, HS_SYNC_BITS, NARROW_BITS));

  always_comb begin
    st_nxt  = st_q;
    cnt_nxt = cnt_q;
    if (!drive) begin
      st_nxt  = ST_IDLE;
      cnt_nxt = '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (tx_valid) begin
            st_nxt  = ST_SYNC_WAIT;
            cnt_nxt = dly - CNT_W'(1);
          end
        end
        ST_SYNC_WAIT: begin
          if (cnt_q == '0) st_nxt = ST_SEND_SYNC;
          else             cnt_nxt = cnt_q - CNT_W'(1);
        end
        ST_SEND_SYNC: st_nxt = ST_DATA;
        ST_DATA: begin
          if (!tx_valid) begin
            st_nxt  = ST_SEND_EOP;
            cnt_nxt = CNT_W'(EOP_CLKS - 1);
          end
        end
        ST_SEND_EOP: begin
          if (cnt_q == '0) st_nxt = ST_IDLE;
          else             cnt_nxt = cnt_q - CNT_W'(1);
        end
        default: st_nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_nxt;
      cnt_q <= cnt_nxt;
    end
  end

  assign state    = st_q;
  assign sync_req = drive && (st_q == ST_SEND_SYNC);
  assign eop_req  = drive && (st_q == ST_SEND_EOP);
  assign ready    = drive && (st_q == ST_DATA);

endmodule

// File: rtl/txh_holdreg.sv
module txh_holdreg #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              wide,
  input  logic              hi_ok,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              lo_vld,
  output logic              hi_vld
);

  localparam int unsigned HALF_W = DATA_W / 2;

  // Upper half is kept only when the wide path is active and qualified.
  function automatic logic [DATA_W-1:0] pack_word(
    input logic [DATA_W-1:0] d,
    input logic              keep_hi
  );
    return keep_hi ? d : {{(DATA_W - HALF_W){1'b0}}, d[HALF_W-1:0]};
  endfunction

  logic keep_hi;
  assign keep_hi = wide && hi_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout   <= '0;
      lo_vld <= 1'b0;
      hi_vld <= 1'b0;
    end else begin
      lo_vld <= load;
      hi_vld <= load && keep_hi;
      if (load) dout <= pack_word(din, keep_hi);
    end
  end

endmodule

// File: rtl/txh_ctrl.sv
module txh_ctrl
  import txh_pkg::*;
#(
  parameter int unsigned DATA_W       = 16,
  parameter int unsigned FS_SYNC_CLKS = 1,
  parameter int unsigned HS_SYNC_BITS = 16,
  parameter int unsigned NARROW_BITS  = 8,
  parameter int unsigned EOP_CLKS     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic              fs_sel,
  input  logic              wide_sel,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_hi_ok,
  output logic              tx_ready,
  output logic              sync_req,
  output logic              eop_req,
  output logic              raw_line,
  output logic [DATA_W-1:0] hold_data,
  output logic              hold_lo_vld,
  output logic              hold_hi_vld
);

  // Named internal events, visible to the bound checker.
  logic       wide_lat;
  logic       drive;
  logic       load_evt;
  txh_state_e seq_state;

  always_ff @(posedge clk) begin
    if (!rst_n) wide_lat <= wide_sel;
  end

  assign drive    = mode_drives(mode_i);
  assign raw_line = (mode_i == MODE_RAW);
  assign load_evt = tx_valid && tx_ready;

  txh_seq #(
    .FS_SYNC_CLKS (FS_SYNC_CLKS),
    .HS_SYNC_BITS (HS_SYNC_BITS),
    .NARROW_BITS  (NARROW_BITS),
    .EOP_CLKS     (EOP_CLKS)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .drive    (drive),
    .fs       (fs_sel),
    .wide     (wide_lat),
    .tx_valid (tx_valid),
    .state    (seq_state),
    .sync_req (sync_req),
    .eop_req  (eop_req),
    .ready    (tx_ready)
  );

  txh_holdreg #(
    .DATA_W (DATA_W)
  ) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load_evt),
    .wide   (wide_lat),
    .hi_ok  (tx_hi_ok),
    .din    (tx_data),
    .dout   (hold_data),
    .lo_vld (hold_lo_vld),
    .hi_vld (hold_hi_vld)
  );

endmodule

// File: rtl/txh_checker.sv
module txh_checker #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode_i,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              sync_req,
  input logic              eop_req,
  input logic              hold_lo_vld,
  input logic              hold_hi_vld,
  input logic              wide_lat
);

  // R2: the SYNC request is a single-cycle pulse
  p_sync_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sync_req |=> !sync_req);

  // R4: ready follows the SYNC cycle while the line is driven
  p_ready_after_sync_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_req ##1 (mode_i[0] == 1'b0)) |-> tx_ready);

  // R4: ready never overlaps a SYNC or EOP request
  p_ready_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_ready && (sync_req || eop_req)));

  // R5: a handshake yields a low-byte strobe one cycle later
  p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> hold_lo_vld);

  // R5: no handshake, no strobe
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && tx_ready) |=> !hold_lo_vld);

  // R6: the 8-bit path never qualifies an upper byte
  p_narrow_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wide_lat |-> !hold_hi_vld);

  // R7: dropping valid during data starts EOP
  p_eop_after_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((tx_ready && !tx_valid) ##1 (mode_i[0] == 1'b0)) |-> eop_req);

  // R8: silent modes load nothing
  p_quiet_no_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_i[0] |=> !hold_lo_vld);

  // R9: the path width never changes outside reset
  p_width_static_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(wide_lat));

endmodule

bind txh_ctrl txh_checker #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_i      (mode_i),
  .tx_valid    (tx_valid),
  .tx_ready    (tx_ready),
  .sync_req    (sync_req),
  .eop_req     (eop_req),
  .hold_lo_vld (hold_lo_vld),
  .hold_hi_vld (hold_hi_vld),
  .wide_lat    (wide_lat)
);

// File: tb/sim_txh_ctrl.sv
module sim_txh_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int EOP_CLKS   = 2;
  localparam int NROWS      = 6;

  // Row layout: {wide, fs, mode[1:0], len[3:0], hi_mask[7:0], exp_delay[3:0]}
  localparam logic [19:0] VEC [NROWS] = '{
    {1'b0, 1'b1, 2'b00, 4'd3, 8'h00, 4'd1},
    {1'b0, 1'b0, 2'b00, 4'd2, 8'hFF, 4'd2},
    {1'b1, 1'b0, 2'b00, 4'd4, 8'h05, 4'd1},
    {1'b1, 1'b1, 2'b00, 4'd1, 8'h01, 4'd1},
    {1'b0, 1'b0, 2'b10, 4'd2, 8'h00, 4'd2},
    {1'b1, 1'b1, 2'b10, 4'd3, 8'h06, 4'd1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_i = 2'b00;
  logic        fs_sel = 1'b0;
  logic        wide_sel = 1'b0;
  logic        tx_valid = 1'b0;
  logic [15:0] tx_data = '0;
  logic        tx_hi_ok = 1'b0;
  logic        tx_ready, sync_req, eop_req, raw_line, hold_lo_vld, hold_hi_vld;
  logic [15:0] hold_data;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  txh_ctrl #(.EOP_CLKS(EOP_CLKS)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .fs_sel(fs_sel), .wide_sel(wide_sel),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_hi_ok(tx_hi_ok), .tx_ready(tx_ready),
    .sync_req(sync_req), .eop_req(eop_req), .raw_line(raw_line), .hold_data(hold_data),
    .hold_lo_vld(hold_lo_vld), .hold_hi_vld(hold_hi_vld)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic w);
    @(negedge clk);
    rst_n = 1'b0; tx_valid = 1'b0; wide_sel = w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    wide_sel = !w;  // R9: later changes must not matter
  endtask

  function automatic logic [15:0] word_of(input int r, input int i);
    return 16'((r + 1) * 16'h1357 + i * 16'h0F1E + 16'h0081);
  endfunction

  task automatic run_row(input int r);
    logic        w, fs, hi, exp_hi;
    logic [1:0]  md;
    int          len, dly, n, m;
    logic [7:0]  mask;
    logic [15:0] wd, exp_w;
    bit          got;
    {w, fs, md} = VEC[r][19:16];
    len  = int'(VEC[r][15:12]);
    mask = VEC[r][11:4];
    dly  = int'(VEC[r][3:0]);
    fs_sel = fs; mode_i = md;
    do_reset(w);
    check(raw_line == (md == 2'b10), "R10 raw_line", 32'(raw_line), 32'(md == 2'b10));
    wd = word_of(r, 0);
    tx_data = wd; tx_hi_ok = mask[0]; tx_valid = 1'b1;
    @(posedge clk);
    n = 0; got = 0;
    for (int k = 0; k < 20 && !got; k++) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (sync_req) got = 1;
    end
    if (fs) check(n == dly, "R2 sync delay full speed", 32'(n), 32'(dly));
    else    check(n == dly, "R3 sync delay high speed", 32'(n), 32'(dly));
    check(tx_ready == 1'b0, "R4 no ready during sync", 32'(tx_ready), 32'd0);
    @(negedge clk);
    check(sync_req == 1'b0, "R2 sync one cycle", 32'(sync_req), 32'd0);
    check(tx_ready == 1'b1, "R4 ready after sync", 32'(tx_ready), 32'd1);
    for (int i = 0; i < len; i++) begin
      wd = word_of(r, i);
      hi = mask[i];
      tx_data = wd; tx_hi_ok = hi;
      @(posedge clk);
      @(negedge clk);
      exp_hi = w && hi;
      exp_w  = exp_hi ? wd : {8'h00, wd[7:0]};
      check(hold_lo_vld == 1'b1, "R5 low strobe", 32'(hold_lo_vld), 32'd1);
      check(hold_data == exp_w, "R6 held word", 32'(hold_data), 32'(exp_w));
      check(hold_hi_vld == exp_hi, "R6 high strobe", 32'(hold_hi_vld), 32'(exp_hi));
      if (i == len - 1) tx_valid = 1'b0;
      else tx_data = word_of(r, i + 1);
    end
    @(posedge clk);
    @(negedge clk);
    check(eop_req == 1'b1, "R7 eop start", 32'(eop_req), 32'd1);
    check(tx_ready == 1'b0, "R7 ready drops", 32'(tx_ready), 32'd0);
    check(hold_lo_vld == 1'b0, "R5 no strobe without valid", 32'(hold_lo_vld), 32'd0);
    m = 1;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (eop_req) m++;
      else break;
    end
    check(m == EOP_CLKS, "R7 eop length", 32'(m), 32'(EOP_CLKS));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check({tx_ready, sync_req, eop_req, hold_lo_vld, hold_hi_vld} == 5'b0,
          "R1 outputs in reset", 32'({tx_ready, sync_req, eop_req, hold_lo_vld, hold_hi_vld}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check({tx_ready, sync_req, eop_req, hold_lo_vld, hold_hi_vld} == 5'b0,
          "R1 outputs after release", 32'({tx_ready, sync_req, eop_req, hold_lo_vld, hold_hi_vld}), 32'd0);

    for (int r = 0; r < NROWS; r++) run_row(r);

    // R8: non-driving and reserved modes stay silent
    fs_sel = 1'b1;
    do_reset(1'b0);
    for (int q = 0; q < 2; q++) begin
      mode_i = (q == 0) ? 2'b01 : 2'b11;
      tx_valid = 1'b1;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        check({tx_ready, sync_req, eop_req, hold_lo_vld} == 4'b0, "R8 quiet mode",
              32'({tx_ready, sync_req, eop_req, hold_lo_vld}), 32'd0);
      end
      check(raw_line == 1'b0, "R10 raw_line off", 32'(raw_line), 32'd0);
      tx_valid = 1'b0;
      @(negedge clk);
    end

    // R8: abort a packet in progress
    mode_i = 2'b00;
    tx_valid = 1'b1; tx_data = 16'h00A5;
    for (int k = 0; k < 20 && !tx_ready; k++) @(negedge clk);
    check(tx_ready == 1'b1, "R4 ready reached", 32'(tx_ready), 32'd1);
    mode_i = 2'b01;
    #1;
    check(tx_ready == 1'b0, "R8 ready drops at once", 32'(tx_ready), 32'd0);
    @(negedge clk);
    check(hold_lo_vld == 1'b0, "R8 no load on abort", 32'(hold_lo_vld), 32'd0);
    tx_valid = 1'b0;
    @(negedge clk);
    mode_i = 2'b00;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check({eop_req, sync_req, tx_ready} == 3'b0, "R8 abandoned without eop",
            32'({eop_req, sync_req, tx_ready}), 32'd0);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule